// File: doc/BRIEF.md
# Serial Configuration EEPROM Loader with Automatic Size Detection

After reset this block pulls the configuration contents out of an external serial-in/serial-out EEPROM and hands them to the rest of the chip one word at a time. The same logic serves both a 64-word and a 256-word device. The device size is not set by a strap or a parameter. The block finds it on the serial wires itself. It sends a read command and then feeds zero address bits one at a time. It counts how many address bits go out before the device answers with its low dummy bit.

Once the address width is known, the block reads every word from address 0 up to the last one, in order. Each word appears with a one-cycle valid strobe and its address, so configuration registers elsewhere can capture it. A done flag marks a complete load. An error flag marks a device whose answer fits neither size, and in that case no words are read. The serial clock comes from the core clock through a divider parameter.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held and in the cycle it is released, chip select, serial clock, serial data out, the valid strobe, the done flag and the error flag are all low.
- R2: Every frame raises chip select with the serial clock low. It then shifts out a start bit of 1 and the read opcode bits 1 then 0, followed by the address bits most significant first. Serial data out changes only while the serial clock is low. Chip select drops only after the clock has returned low, so each frame carries the 3-bit header 110.
- R3: The serial clock period inside a frame is exactly 2*SK_HALF_DIV core cycles, and at CLK_FREQ_HZ this is no longer than 1 us (rate of at least 1 MHz).
- R4: Detection sends the header and then zero address bits one at a time, and samples serial data in at each rising edge. The number of address bits sent before data in is first seen low becomes the address width. A width of 6 selects 64 words, a width of 8 selects 256 words, and addr_bits reports that width.
- R5: If data in is first seen low after any number of address bits other than 6 or 8, or is still high after 8 address bits, load_err goes high. In that case no read frame follows, no valid strobe appears and load_done stays low.
- R6: After a successful detection, words 0 through 2^width-1 are read in ascending order, one frame per word. In each frame the dummy bit is skipped and then 16 data bits are taken most significant first, sampled at the rising serial clock edges. Each word is presented with a one-cycle cfg_valid together with its cfg_addr and cfg_data.
- R7: One cycle after the last word's strobe, load_done rises and stays high until reset. Chip select stays low and no further strobes appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| cfg_valid | output | 1 | One-cycle strobe for each loaded word |
| cfg_addr | output | 8 | Word address of the presented word |
| cfg_data | output | 16 | Presented configuration word |
| addr_bits | output | 4 | Detected address width (6 or 8) |
| load_done | output | 1 | All words loaded |
| load_err | output | 1 | Device size not recognised |

## Verification
The bench builds the block with a 200 MHz core clock and a half-period divider of 2, so the serial clock runs at 50 MHz. A whole 256-word load then fits in a few tens of thousands of cycles. This lets the bench sweep every word of both device sizes against a behavioural EEPROM whose contents are computed from the address and a seed. The same model is also set to answer after 0, 5, 7, 9 and 10 address bits. These settings reach the error path, both where the dummy bit arrives early or at an odd width and where it never arrives within eight bits.

// File: rtl/eeld_pkg.sv
// Package: shared types and constants for the serial EEPROM loader.
// Assumes a three-wire read command of start bit plus two opcode bits.
package eeld_pkg;
    localparam int          HDR_W  = 3;
    localparam logic [2:0]  RD_HDR = 3'b110;

    typedef enum logic [2:0] {
        FR_IDLE, FR_SETUP, FR_HIGH, FR_LOW, FR_TAIL, FR_GAP
    } frame_state_t;

    typedef enum logic [2:0] {
        SQ_DETECT, SQ_DET_WAIT, SQ_READ, SQ_READ_WAIT, SQ_DONE, SQ_FAIL
    } seq_state_t;
endpackage

// File: rtl/eeld_tick.sv
// Module: half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF_DIV core cycles while run is high and
// restarts its count whenever run is low. Assumes HALF_DIV >= 2.
module eeld_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

    // Count core cycles inside each half period of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/eeld_frame.sv
// Module: one chip-select frame on the serial EEPROM wires.
// On go, loads a command word and clocks edge_total rising edges. It shifts
// the command out MSB first (zeros after it) and changes data out only while
// the clock is low. rise pulses in the first cycle of each high half and
// carries the index of that edge. stop ends the frame at the next falling
// edge. Assumes go arrives only while the engine is idle.
module eeld_frame
    import eeld_pkg::*;
#(
    parameter int CMD_W    = 11,
    parameter int EDGE_W   = 5,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [EDGE_W-1:0] edge_total,
    input  logic              stop,
    output logic              cs,
    output logic              sk,
    output logic              di,
    output logic              rise,
    output logic [EDGE_W-1:0] rise_idx,
    output logic              done
);
    frame_state_t      st_q;
    logic [CMD_W-1:0]  sr_q;
    logic [EDGE_W-1:0] cnt_q;
    logic              tick;

    eeld_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q != FR_IDLE),
        .tick (tick)
    );

    // Frame sequencing: select, clock halves, shift, deselect, gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= FR_IDLE;
            sr_q     <= '0;
            cnt_q    <= '0;
            cs       <= 1'b0;
            sk       <= 1'b0;
            di       <= 1'b0;
            rise     <= 1'b0;
            rise_idx <= '0;
            done     <= 1'b0;
        end else begin
            rise <= 1'b0;
            done <= 1'b0;
            unique case (st_q)
                FR_IDLE: begin
                    if (go) begin
                        cs    <= 1'b1;
                        sk    <= 1'b0;
                        di    <= cmd[CMD_W-1];
                        sr_q  <= {cmd[CMD_W-2:0], 1'b0};
                        cnt_q <= '0;
                        st_q  <= FR_SETUP;
                    end
                end
                FR_SETUP, FR_LOW: begin
                    if (tick) begin
                        sk       <= 1'b1;
                        rise     <= 1'b1;
                        rise_idx <= cnt_q;
                        cnt_q    <= cnt_q + 1'b1;
                        st_q     <= FR_HIGH;
                    end
                end
                FR_HIGH: begin
                    if (tick) begin
                        sk <= 1'b0;
                        if (stop || cnt_q == edge_total) begin
                            st_q <= FR_TAIL;
                        end else begin
                            di   <= sr_q[CMD_W-1];
                            sr_q <= {sr_q[CMD_W-2:0], 1'b0};
                            st_q <= FR_LOW;
                        end
                    end
                end
                FR_TAIL: begin
                    if (tick) begin
                        cs   <= 1'b0;
                        di   <= 1'b0;
                        st_q <= FR_GAP;
                    end
                end
                FR_GAP: begin
                    if (tick) begin
                        done <= 1'b1;
                        st_q <= FR_IDLE;
                    end
                end
                default: st_q <= FR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_eeprom_loader.sv
// Module: configuration loader for a 64- or 256-word serial EEPROM.
// After reset it runs one detection frame with zero address bits to find
// the address width. It then reads every word in ascending order, presenting
// each with a strobe. Assumes ee_do is already synchronous to clk or slow
// enough to be stable over a serial clock high half.
module cfg_eeprom_loader
    import eeld_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int SK_HALF_DIV = 4,
    parameter int DATA_W      = 16,
    parameter int SMALL_ABITS = 6,
    parameter int LARGE_ABITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do,
    output logic              cfg_valid,
    output logic [LARGE_ABITS-1:0] cfg_addr,
    output logic [DATA_W-1:0] cfg_data,
    output logic [3:0]        addr_bits,
    output logic              load_done,
    output logic              load_err
);
    localparam int MAX_ABITS = LARGE_ABITS;
    localparam int ADDR_W    = MAX_ABITS;
    localparam int CMD_W     = HDR_W + MAX_ABITS;
    localparam int MAX_EDGES = HDR_W + MAX_ABITS + 1 + DATA_W;
    localparam int EDGE_W    = $clog2(MAX_EDGES + 1);
    localparam int DET_EDGES = HDR_W + MAX_ABITS + 1;

    seq_state_t        seq_q;
    logic              go_q, hit_q, found_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [EDGE_W-1:0] total_q;
    logic [3:0]        aw_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] shf_q;
    logic              f_rise, f_done;
    logic [EDGE_W-1:0] f_idx;
    logic [EDGE_W-1:0] det_bit;
    logic [ADDR_W:0]   n_words;
    logic              last_word;

    assign det_bit   = f_idx - EDGE_W'(HDR_W);
    assign n_words   = (ADDR_W+1)'(1) << aw_q;
    assign last_word = ({1'b0, addr_q} == n_words - 1'b1);
    assign addr_bits = aw_q;

    eeld_frame #(
        .CMD_W   (CMD_W),
        .EDGE_W  (EDGE_W),
        .HALF_DIV(SK_HALF_DIV)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_q),
        .cmd       (cmd_q),
        .edge_total(total_q),
        .stop      (hit_q && seq_q == SQ_DET_WAIT),
        .cs        (ee_cs),
        .sk        (ee_sk),
        .di        (ee_di),
        .rise      (f_rise),
        .rise_idx  (f_idx),
        .done      (f_done)
    );

    // Load sequencing: detect width, then read each word and present it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= SQ_DETECT;
            go_q      <= 1'b0;
            hit_q     <= 1'b0;
            found_q   <= 1'b0;
            cmd_q     <= '0;
            total_q   <= '0;
            aw_q      <= '0;
            addr_q    <= '0;
            shf_q     <= '0;
            cfg_valid <= 1'b0;
            cfg_addr  <= '0;
            cfg_data  <= '0;
            load_done <= 1'b0;
            load_err  <= 1'b0;
        end else begin
            go_q      <= 1'b0;
            cfg_valid <= 1'b0;
            unique case (seq_q)
                SQ_DETECT: begin
                    cmd_q   <= {RD_HDR, {MAX_ABITS{1'b0}}};
                    total_q <= EDGE_W'(DET_EDGES);
                    hit_q   <= 1'b0;
                    found_q <= 1'b0;
                    go_q    <= 1'b1;
                    seq_q   <= SQ_DET_WAIT;
                end
                SQ_DET_WAIT: begin
                    if (f_rise && f_idx >= EDGE_W'(HDR_W) && !hit_q && !ee_do) begin
                        hit_q <= 1'b1;
                        if (det_bit == EDGE_W'(SMALL_ABITS) ||
                            det_bit == EDGE_W'(LARGE_ABITS)) begin
                            found_q <= 1'b1;
                            aw_q    <= 4'(det_bit);
                        end
                    end
                    if (f_done) begin
                        if (found_q) begin
                            seq_q <= SQ_READ;
                        end else begin
                            load_err <= 1'b1;
                            seq_q    <= SQ_FAIL;
                        end
                    end
                end
                SQ_READ: begin
                    cmd_q   <= {RD_HDR, ADDR_W'(addr_q << (4'(MAX_ABITS) - aw_q))};
                    total_q <= EDGE_W'(HDR_W + 1 + DATA_W) + EDGE_W'(aw_q);
                    go_q    <= 1'b1;
                    seq_q   <= SQ_READ_WAIT;
                end
                SQ_READ_WAIT: begin
                    if (f_rise && f_idx > EDGE_W'(HDR_W) + EDGE_W'(aw_q)) begin
                        shf_q <= {shf_q[DATA_W-2:0], ee_do};
                    end
                    if (f_done) begin
                        cfg_valid <= 1'b1;
                        cfg_addr  <= addr_q;
                        cfg_data  <= shf_q;
                        if (last_word) begin
                            seq_q <= SQ_DONE;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                            seq_q  <= SQ_READ;
                        end
                    end
                end
                SQ_DONE: load_done <= 1'b1;
                SQ_FAIL: load_err  <= 1'b1;
                default: seq_q <= SQ_FAIL;
            endcase
        end
    end
endmodule

// File: rtl/eeld_checker.sv
// Module: protocol and ordering checks for cfg_eeprom_loader, bound to it.
// Tracks the serial clock period and the expected word address with its
// own counters.
module eeld_checker #(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int SK_HALF_DIV = 4,
    parameter int SMALL_ABITS = 6,
    parameter int LARGE_ABITS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ee_cs,
    input logic                   ee_sk,
    input logic                   ee_di,
    input logic                   cfg_valid,
    input logic [LARGE_ABITS-1:0] cfg_addr,
    input logic [3:0]             addr_bits,
    input logic                   load_done,
    input logic                   load_err
);
    localparam int MAX_CYC = CLK_FREQ_HZ / 1_000_000;

    logic        sk_d;
    logic        seen_q;
    logic [15:0] per_q;
    logic [LARGE_ABITS:0] exp_q;

    // Measure core cycles between rising serial clock edges in a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !ee_cs) begin
            seen_q <= 1'b0;
            per_q  <= '0;
        end else if (ee_sk && !sk_d) begin
            seen_q <= 1'b1;
            per_q  <= 16'd1;
        end else if (per_q != 16'hFFFF) begin
            per_q <= per_q + 1'b1;
        end
    end

    // Remember the previous serial clock level and count presented words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_d  <= 1'b0;
            exp_q <= '0;
        end else begin
            sk_d <= ee_sk;
            if (cfg_valid) exp_q <= exp_q + 1'b1;
        end
    end

    AST_CS_RISE_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> !ee_sk); // R2
    AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> $stable(ee_di)); // R2
    AST_CS_DROP_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> !ee_sk && !$past(ee_sk)); // R2
    AST_SK_MIN_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cs && ee_sk && !sk_d && seen_q) |-> per_q <= 16'(MAX_CYC)); // R3
    AST_SK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cs && ee_sk && !sk_d && seen_q) |-> per_q == 16'(2 * SK_HALF_DIV)); // R3
    AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (addr_bits == 4'(SMALL_ABITS) || addr_bits == 4'(LARGE_ABITS))); // R4
    AST_ERR_NO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> !cfg_valid && !load_done && exp_q == '0); // R5
    AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> {1'b0, cfg_addr} == exp_q); // R6
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> exp_q == ((LARGE_ABITS+1)'(1) << addr_bits)); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done && !cfg_valid && !ee_cs); // R7
endmodule

bind cfg_eeprom_loader eeld_checker #(
    .CLK_FREQ_HZ(CLK_FREQ_HZ),
    .SK_HALF_DIV(SK_HALF_DIV),
    .SMALL_ABITS(SMALL_ABITS),
    .LARGE_ABITS(LARGE_ABITS)
) u_eeld_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ee_cs    (ee_cs),
    .ee_sk    (ee_sk),
    .ee_di    (ee_di),
    .cfg_valid(cfg_valid),
    .cfg_addr (cfg_addr),
    .addr_bits(addr_bits),
    .load_done(load_done),
    .load_err (load_err)
);

// File: tb/cfg_eeprom_loader_test.sv
// Bench: behavioural EEPROM with a settable address width, full-contents
// sweeps for both sizes and error sweeps for illegal widths.
module cfg_eeprom_loader_test;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b1;
    logic        cfg_valid;
    logic [7:0]  cfg_addr;
    logic [15:0] cfg_data;
    logic [3:0]  addr_bits;
    logic        load_done, load_err;

    always #2.5 clk = ~clk;

    cfg_eeprom_loader #(
        .CLK_FREQ_HZ(200_000_000),
        .SK_HALF_DIV(HALF)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .addr_bits(addr_bits), .load_done(load_done), .load_err(load_err)
    );

    function automatic logic [15:0] word_of(int a, int s);
        int v;
        v = a * 40503 + s * 977 + (a << 9);
        return v[15:0] ^ {a[7:0], ~a[7:0]};
    endfunction

    // Behavioural EEPROM: header, m_aw address bits, dummy zero, 16 data bits.
    int          m_aw = 6, m_seed = 0, m_cnt = 0, m_frames = 0, m_hdr_bad = 0;
    logic [2:0]  m_hdr = '0;
    logic [7:0]  m_addr = '0;
    logic [15:0] m_word = '0;
    logic        cs_p = 1'b0, sk_p = 1'b0;
    always @(ee_sk or ee_cs) begin
        if (ee_cs && !cs_p) begin
            m_cnt = 0; m_addr = '0; m_hdr = '0;
        end else if (!ee_cs && cs_p) begin
            ee_do = 1'b1;
            m_frames++;
            if (m_hdr != 3'b110) m_hdr_bad++;
        end else if (ee_cs && ee_sk && !sk_p) begin
            if (m_cnt < 3) m_hdr = {m_hdr[1:0], ee_di};
            else if (m_cnt < 3 + m_aw) m_addr = {m_addr[6:0], ee_di};
            m_cnt++;
        end else if (ee_cs && !ee_sk && sk_p) begin
            if (m_cnt == 3 + m_aw) begin
                ee_do  = 1'b0;
                m_word = word_of(int'(m_addr), m_seed);
            end else if (m_cnt > 3 + m_aw && m_cnt <= 3 + m_aw + 16) begin
                ee_do = m_word[15 - (m_cnt - 4 - m_aw)];
            end
        end
        cs_p = ee_cs;
        sk_p = ee_sk;
    end

    // Monitor: word order/content and serial clock period.
    int mon_checks = 0, mon_fails = 0, words = 0, per = 0;
    bit have_rise = 0;
    logic sk_m = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            words = 0; have_rise = 0; per = 0;
        end else begin
            if (cfg_valid) begin
                mon_checks++;
                if (int'(cfg_addr) != words || cfg_data != word_of(words, m_seed)) begin
                    mon_fails++;
                    $display("FAIL R6 word: addr=%0d data=%h expected addr=%0d data=%h",
                             cfg_addr, cfg_data, words, word_of(words, m_seed));
                end
                words++;
            end
            if (!ee_cs) have_rise = 0;
            if (ee_cs && ee_sk && !sk_m) begin
                if (have_rise) begin
                    mon_checks++;
                    if (per != 2 * HALF) begin
                        mon_fails++;
                        $display("FAIL R3 sk period: got %0d expected %0d", per, 2 * HALF);
                    end
                end
                have_rise = 1; per = 0;
            end
            per++;
        end
        sk_m = ee_sk;
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(int aw, int seed, bit good);
        int base_fr, base_bad, nw, wait_cyc;
        m_aw = aw; m_seed = seed;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, cfg_valid, load_done, load_err} == 6'b0, "R1 reset outputs",
            int'({ee_cs, ee_sk, ee_di, cfg_valid, load_done, load_err}), 0);
        base_fr = m_frames; base_bad = m_hdr_bad;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ee_cs && !load_done && !load_err, "R1 first cycle after reset",
            int'({ee_cs, load_done, load_err}), 0);
        wait_cyc = 0;
        while (!load_done && !load_err && wait_cyc < 60000) begin
            @(negedge clk); wait_cyc++;
        end
        nw = good ? (1 << aw) : 0;
        chk(m_hdr_bad == base_bad, "R2 frame header 110", m_hdr_bad - base_bad, 0);
        chk(m_frames - base_fr == 1 + nw, "R2 frame count", m_frames - base_fr, 1 + nw);
        if (good) begin
            chk(load_done && !load_err, "R7 done flag", int'({load_done, load_err}), 2);
            chk(int'(addr_bits) == aw, "R4 detected width", int'(addr_bits), aw);
            chk(words == nw, "R6 word count", words, nw);
        end else begin
            chk(load_err && !load_done, "R5 error flag", int'({load_done, load_err}), 1);
            chk(words == 0, "R5 no words read", words, 0);
        end
        repeat (200) begin
            @(negedge clk);
            if (ee_cs || cfg_valid) break;
        end
        chk(!ee_cs && words == nw, "R7 quiet after end", words + (ee_cs ? 1000 : 0), nw);
        chk(load_done == good && load_err == !good, "R7 flags held",
            int'({load_done, load_err}), good ? 2 : 1);
    endtask

    initial begin
        run_case(6, 11, 1'b1);
        run_case(8, 23, 1'b1);
        run_case(6, 5, 1'b1);
        run_case(7, 3, 1'b0);
        run_case(5, 3, 1'b0);
        run_case(0, 3, 1'b0);
        run_case(9, 3, 1'b0);
        run_case(10, 3, 1'b0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors + mon_fails, checks + mon_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks",
                     errors + mon_fails + 1, checks + mon_checks + 1);
            $finish;
        end
    end
endmodule